// File: doc/BRIEF.md
# Legacy multi-function I/O configuration front end

This block is the configuration side of a PC-style multi-function I/O controller. A host reaches it over a byte-wide I/O bus with separate write and read strobes. Two adjacent port addresses are decoded: a key/index port and a data port one address above it. Configuration is locked behind a key. Out of reset the unit is in the run state. A fixed enter byte on the key port opens the configuration state, and a fixed exit byte closes it again.

While unlocked, the host writes a register number to the index port and then reads or writes the data port to move the byte held at that number. One global register holds a logical-device number. It chooses which bank of per-device registers the data port reaches. The device identity registers are global and read-only. A further bank, chosen by the auxiliary device number, holds a set of GPIO control bytes.

Each bank's enable bit, its two 16-bit base addresses and its two interrupt selects are brought out as flat vectors for downstream address decoders. Two states are named: `ST_RUN` (locked) and `ST_CFG` (unlocked). The transitions are:
- `ST_RUN -> ST_CFG` on a write of 0x55 to the key port.
- `ST_CFG -> ST_RUN` on a write of 0xAA to the key port.

Top module: `sio_cfg_unit`

## Requirements
- R1: After reset the unit is in `ST_RUN` (`cfg_active`=0). Every enable bit, base address and interrupt select is 0. The logical-device number and the index are 0.
- R2: In `ST_RUN`, writes to the data port change nothing. Reads of the key or data port return 0xFF. A key-port byte other than 0x55 leaves the unit locked.
- R3: A key-port write of 0x55 in `ST_RUN` enters `ST_CFG`. A key-port write of 0xAA in `ST_CFG` returns to `ST_RUN` without changing the index.
- R4: The key/index port is address 0x03F0 and the data port is 0x03F1. In `ST_CFG` any key-port byte other than 0xAA becomes the index, and a key-port read returns the index. Accesses to other addresses change nothing, and reads of them return 0x00.
- R5: Index 0x07 is the logical-device number. It is a full byte that reads back as written and selects the bank for per-device indexes. Banks 0 to 8 exist, and 8 is the auxiliary bank.
- R6: Index 0x20 reads 0x30 and index 0x21 reads 0x01. Writes to either are ignored.
- R7: Index 0x30 is the enable register. Bit 0 of the written byte drives `dev_enable[ldn]`, and the register reads back as 0x00 or 0x01.
- R8: Indexes 0x60 (high byte) and 0x61 (low byte) form the primary base. Indexes 0x62 (high) and 0x63 (low) form the secondary base. Device n occupies bits [16n+15:16n] of `dev_base_pri` and `dev_base_sec`.
- R9: Index 0x70 is the primary and 0x72 the secondary interrupt select. Device n occupies bits [8n+7:8n] of `dev_irq_pri` and `dev_irq_sec`. Indexes 0xF0 and 0xF1 are per-device decoder bytes that read back as written.
- R10: In bank 8, indexes 0xC0 to 0xEF are GPIO control registers. Each keeps bits 4:0 of the written byte: bit 0 direction (1 = input), bit 1 invert, bit 2 combined-interrupt enable, bits 4:3 function select. Bits 7:5 read as 0.
- R11: Unimplemented indexes read 0x00. With a logical-device number of 9 or more, per-device writes are ignored and per-device reads return 0x00.
- R12: When both strobes are high on the data port in the same cycle, the read returns the value held before the write, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | I/O address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the current state |
| cfg_active | output | 1 | High while unlocked |
| dev_enable | output | 9 | Enable bit per logical device |
| dev_base_pri | output | 144 | Primary base address per device, 16 bits each |
| dev_base_sec | output | 144 | Secondary base address per device, 16 bits each |
| dev_irq_pri | output | 72 | Primary interrupt select per device, 8 bits each |
| dev_irq_sec | output | 72 | Secondary interrupt select per device, 8 bits each |

## Verification
A data-port read and a data-port write can fall in the same cycle when the host raises both strobes together. The bench provokes this at several registers, including the logical-device number and the enable register. The read value is judged against the bench model taken before the write is applied. A later read and the device outputs then confirm that the write landed. Random traffic also places key bytes, index loads and data accesses back to back. The outputs are compared with the model after every operation sequence.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
    typedef enum logic [0:0] {
        ST_RUN = 1'b0,
        ST_CFG = 1'b1
    } key_state_e;

    localparam logic [7:0] KEY_ENTER  = 8'h55;
    localparam logic [7:0] KEY_EXIT   = 8'hAA;

    localparam logic [7:0] IDX_LDN     = 8'h07;
    localparam logic [7:0] IDX_CHIP_ID = 8'h20;
    localparam logic [7:0] IDX_CHIP_RV = 8'h21;
    localparam logic [7:0] IDX_ENABLE  = 8'h30;
    localparam logic [7:0] IDX_PRI_HI  = 8'h60;
    localparam logic [7:0] IDX_PRI_LO  = 8'h61;
    localparam logic [7:0] IDX_SEC_HI  = 8'h62;
    localparam logic [7:0] IDX_SEC_LO  = 8'h63;
    localparam logic [7:0] IDX_IRQ_PRI = 8'h70;
    localparam logic [7:0] IDX_IRQ_SEC = 8'h72;
    localparam logic [7:0] IDX_DEC0    = 8'hF0;
    localparam logic [7:0] IDX_DEC1    = 8'hF1;

    localparam logic [7:0] CHIP_ID_VAL = 8'h30;
    localparam logic [7:0] CHIP_RV_VAL = 8'h01;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr_i,
    input  logic [7:0] key_data_i,
    output logic       cfg_mode_o,
    output logic       idx_load_o
);
    key_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: if (key_wr_i && key_data_i == KEY_ENTER) state_d = ST_CFG;
            ST_CFG: if (key_wr_i && key_data_i == KEY_EXIT)  state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        cfg_mode_o = 1'b0;
        idx_load_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                cfg_mode_o = 1'b0;
                idx_load_o = 1'b0;
            end
            ST_CFG: begin
                cfg_mode_o = 1'b1;
                idx_load_o = key_wr_i && (key_data_i != KEY_EXIT);
            end
            default: begin
                cfg_mode_o = 1'b0;
                idx_load_o = 1'b0;
            end
        endcase
    end

    AST_KEY_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode_o && key_wr_i && key_data_i == KEY_ENTER) |=> cfg_mode_o); // R3
    AST_KEY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode_o && key_wr_i && key_data_i == KEY_EXIT) |=> !cfg_mode_o); // R3
    AST_RUN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode_o && !(key_wr_i && key_data_i == KEY_ENTER)) |=> !cfg_mode_o); // R2
endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
    import sio_cfg_pkg::*;
#(
    parameter int NUM_DEV = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [7:0]             ldn_i,
    input  logic [7:0]             idx_i,
    input  logic [7:0]             wdata_i,
    output logic                   rd_hit_o,
    output logic [7:0]             rd_data_o,
    output logic [NUM_DEV-1:0]     enable_o,
    output logic [NUM_DEV*16-1:0]  base_pri_o,
    output logic [NUM_DEV*16-1:0]  base_sec_o,
    output logic [NUM_DEV*8-1:0]   irq_pri_o,
    output logic [NUM_DEV*8-1:0]   irq_sec_o
);
    logic        en_q   [NUM_DEV];
    logic [15:0] pri_q  [NUM_DEV];
    logic [15:0] sec_q  [NUM_DEV];
    logic [7:0]  ipri_q [NUM_DEV];
    logic [7:0]  isec_q [NUM_DEV];
    logic [7:0]  dec0_q [NUM_DEV];
    logic [7:0]  dec1_q [NUM_DEV];

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        logic sel;
        assign sel = wr_en_i && (ldn_i == 8'(d));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[d]   <= 1'b0;
                pri_q[d]  <= '0;
                sec_q[d]  <= '0;
                ipri_q[d] <= '0;
                isec_q[d] <= '0;
                dec0_q[d] <= '0;
                dec1_q[d] <= '0;
            end else if (sel) begin
                unique case (idx_i)
                    IDX_ENABLE:  en_q[d]         <= wdata_i[0];
                    IDX_PRI_HI:  pri_q[d][15:8]  <= wdata_i;
                    IDX_PRI_LO:  pri_q[d][7:0]   <= wdata_i;
                    IDX_SEC_HI:  sec_q[d][15:8]  <= wdata_i;
                    IDX_SEC_LO:  sec_q[d][7:0]   <= wdata_i;
                    IDX_IRQ_PRI: ipri_q[d]       <= wdata_i;
                    IDX_IRQ_SEC: isec_q[d]       <= wdata_i;
                    IDX_DEC0:    dec0_q[d]       <= wdata_i;
                    IDX_DEC1:    dec1_q[d]       <= wdata_i;
                    default: ;
                endcase
            end
        end

        assign enable_o[d]             = en_q[d];
        assign base_pri_o[d*16 +: 16]  = pri_q[d];
        assign base_sec_o[d*16 +: 16]  = sec_q[d];
        assign irq_pri_o[d*8 +: 8]     = ipri_q[d];
        assign irq_sec_o[d*8 +: 8]     = isec_q[d];

        AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (sel && idx_i == IDX_ENABLE) |=> (enable_o[d] == $past(wdata_i[0]))); // R7
        AST_PRI_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (sel && idx_i == IDX_PRI_LO) |=> (base_pri_o[d*16 +: 8] == $past(wdata_i))); // R8
    end

    always_comb begin
        rd_hit_o  = 1'b0;
        rd_data_o = 8'h00;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (ldn_i == 8'(d)) begin
                rd_hit_o = 1'b1;
                unique case (idx_i)
                    IDX_ENABLE:  rd_data_o = {7'b0, en_q[d]};
                    IDX_PRI_HI:  rd_data_o = pri_q[d][15:8];
                    IDX_PRI_LO:  rd_data_o = pri_q[d][7:0];
                    IDX_SEC_HI:  rd_data_o = sec_q[d][15:8];
                    IDX_SEC_LO:  rd_data_o = sec_q[d][7:0];
                    IDX_IRQ_PRI: rd_data_o = ipri_q[d];
                    IDX_IRQ_SEC: rd_data_o = isec_q[d];
                    IDX_DEC0:    rd_data_o = dec0_q[d];
                    IDX_DEC1:    rd_data_o = dec1_q[d];
                    default:     rd_hit_o  = 1'b0;
                endcase
            end
        end
    end

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(enable_o) && $stable(base_pri_o) && $stable(base_sec_o)
                      && $stable(irq_pri_o) && $stable(irq_sec_o))); // R2
endmodule

// File: rtl/sio_aux_bank.sv
module sio_aux_bank #(
    parameter int         GPIO_COUNT = 48,
    parameter logic [7:0] GPIO_FIRST = 8'hC0,
    parameter logic [7:0] AUX_LDN    = 8'd8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [7:0] ldn_i,
    input  logic [7:0] idx_i,
    input  logic [7:0] wdata_i,
    output logic       rd_hit_o,
    output logic [7:0] rd_data_o
);
    localparam int OFS_W = (GPIO_COUNT > 1) ? $clog2(GPIO_COUNT) : 1;
    localparam logic [8:0] LIMIT = 9'(GPIO_FIRST) + 9'(GPIO_COUNT);

    logic [4:0]       gpio_q [GPIO_COUNT];
    logic             in_bank;
    logic [7:0]       rel;
    logic [OFS_W-1:0] ofs;

    assign in_bank = (ldn_i == AUX_LDN) && (idx_i >= GPIO_FIRST)
                     && ({1'b0, idx_i} < LIMIT);
    assign rel     = idx_i - GPIO_FIRST;
    assign ofs     = rel[OFS_W-1:0];

    for (genvar g = 0; g < GPIO_COUNT; g++) begin : g_gpio
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                gpio_q[g] <= '0;
            else if (wr_en_i && in_bank && ofs == OFS_W'(g))
                gpio_q[g] <= wdata_i[4:0];
        end
    end

    always_comb begin
        rd_hit_o  = in_bank;
        rd_data_o = in_bank ? {3'b000, gpio_q[ofs]} : 8'h00;
    end

    AST_GPIO_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit_o |-> (rd_data_o[7:5] == 3'b000)); // R10
endmodule

// File: rtl/sio_cfg_unit.sv
module sio_cfg_unit
    import sio_cfg_pkg::*;
#(
    parameter int          NUM_DEV    = 9,
    parameter logic [15:0] KEY_PORT   = 16'h03F0,
    parameter logic [7:0]  AUX_LDN    = 8'd8,
    parameter logic [7:0]  GPIO_FIRST = 8'hC0,
    parameter int          GPIO_COUNT = 48
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [15:0]            bus_addr,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [7:0]             bus_wdata,
    output logic [7:0]             bus_rdata,
    output logic                   cfg_active,
    output logic [NUM_DEV-1:0]     dev_enable,
    output logic [NUM_DEV*16-1:0]  dev_base_pri,
    output logic [NUM_DEV*16-1:0]  dev_base_sec,
    output logic [NUM_DEV*8-1:0]   dev_irq_pri,
    output logic [NUM_DEV*8-1:0]   dev_irq_sec
);
    localparam logic [15:0] DATA_PORT = KEY_PORT + 16'd1;

    logic       at_key, at_data;
    logic       key_wr, idx_load, data_wr;
    logic [7:0] index_q, ldn_q;
    logic       dev_hit, aux_hit;
    logic [7:0] dev_rdata, aux_rdata;

    assign at_key  = (bus_addr == KEY_PORT);
    assign at_data = (bus_addr == DATA_PORT);
    assign key_wr  = bus_wr && at_key;
    assign data_wr = cfg_active && bus_wr && at_data;

    sio_key_fsm i_key_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_wr_i   (key_wr),
        .key_data_i (bus_wdata),
        .cfg_mode_o (cfg_active),
        .idx_load_o (idx_load)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q <= '0;
            ldn_q   <= '0;
        end else begin
            if (idx_load)                        index_q <= bus_wdata;
            if (data_wr && index_q == IDX_LDN)   ldn_q   <= bus_wdata;
        end
    end

    sio_dev_bank #(.NUM_DEV(NUM_DEV)) i_dev_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (data_wr),
        .ldn_i      (ldn_q),
        .idx_i      (index_q),
        .wdata_i    (bus_wdata),
        .rd_hit_o   (dev_hit),
        .rd_data_o  (dev_rdata),
        .enable_o   (dev_enable),
        .base_pri_o (dev_base_pri),
        .base_sec_o (dev_base_sec),
        .irq_pri_o  (dev_irq_pri),
        .irq_sec_o  (dev_irq_sec)
    );

    sio_aux_bank #(
        .GPIO_COUNT (GPIO_COUNT),
        .GPIO_FIRST (GPIO_FIRST),
        .AUX_LDN    (AUX_LDN)
    ) i_aux_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (data_wr),
        .ldn_i     (ldn_q),
        .idx_i     (index_q),
        .wdata_i   (bus_wdata),
        .rd_hit_o  (aux_hit),
        .rd_data_o (aux_rdata)
    );

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd && (at_key || at_data)) begin
            if (!cfg_active)       bus_rdata = 8'hFF;
            else if (at_key)       bus_rdata = index_q;
            else begin
                unique case (index_q)
                    IDX_LDN:     bus_rdata = ldn_q;
                    IDX_CHIP_ID: bus_rdata = CHIP_ID_VAL;
                    IDX_CHIP_RV: bus_rdata = CHIP_RV_VAL;
                    default: begin
                        if (dev_hit)      bus_rdata = dev_rdata;
                        else if (aux_hit) bus_rdata = aux_rdata;
                        else              bus_rdata = 8'h00;
                    end
                endcase
            end
        end
    end

    AST_LDN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_active |=> $stable(ldn_q)); // R2
    AST_INDEX_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_active |=> $stable(index_q)); // R2
    AST_EXIT_KEEPS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_active && key_wr && bus_wdata == KEY_EXIT) |=> $stable(index_q)); // R3
    AST_LDN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && index_q == IDX_LDN) |=> (ldn_q == $past(bus_wdata))); // R5
endmodule

// File: tb/test_sio_cfg_unit.sv
module test_sio_cfg_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NDEV = 9;
    localparam logic [15:0] KP = 16'h03F0;
    localparam logic [15:0] DP = 16'h03F1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic cfg_active;
    logic [NDEV-1:0] dev_enable;
    logic [NDEV*16-1:0] dev_base_pri, dev_base_sec;
    logic [NDEV*8-1:0] dev_irq_pri, dev_irq_sec;

    int n_checks = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_cfg_unit i_sio_cfg_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_active(cfg_active), .dev_enable(dev_enable),
        .dev_base_pri(dev_base_pri), .dev_base_sec(dev_base_sec),
        .dev_irq_pri(dev_irq_pri), .dev_irq_sec(dev_irq_sec)
    );

    // reference model
    logic        m_cfg;
    logic [7:0]  m_idx, m_ldn;
    logic        m_en [NDEV];
    logic [15:0] m_pri [NDEV], m_sec [NDEV];
    logic [7:0]  m_ip [NDEV], m_is [NDEV], m_d0 [NDEV], m_d1 [NDEV];
    logic [4:0]  m_g [48];

    task automatic model_reset();
        m_cfg = 1'b0; m_idx = 8'h00; m_ldn = 8'h00;
        for (int d = 0; d < NDEV; d++) begin
            m_en[d] = 1'b0; m_pri[d] = '0; m_sec[d] = '0;
            m_ip[d] = '0; m_is[d] = '0; m_d0[d] = '0; m_d1[d] = '0;
        end
        for (int g = 0; g < 48; g++) m_g[g] = '0;
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] v);
        if (a == KP) begin
            if (!m_cfg) begin
                if (v == 8'h55) m_cfg = 1'b1;
            end else if (v == 8'hAA) m_cfg = 1'b0;
            else m_idx = v;
        end else if (a == DP && m_cfg) begin
            if (m_idx == 8'h07) m_ldn = v;
            else if (m_ldn < NDEV) begin
                case (m_idx)
                    8'h30: m_en[m_ldn] = v[0];
                    8'h60: m_pri[m_ldn][15:8] = v;
                    8'h61: m_pri[m_ldn][7:0] = v;
                    8'h62: m_sec[m_ldn][15:8] = v;
                    8'h63: m_sec[m_ldn][7:0] = v;
                    8'h70: m_ip[m_ldn] = v;
                    8'h72: m_is[m_ldn] = v;
                    8'hF0: m_d0[m_ldn] = v;
                    8'hF1: m_d1[m_ldn] = v;
                    default: if (m_ldn == 8 && m_idx >= 8'hC0 && m_idx <= 8'hEF)
                                 m_g[m_idx - 8'hC0] = v[4:0];
                endcase
            end
        end
    endtask

    function automatic logic [7:0] model_read(input logic [15:0] a);
        logic [7:0] r;
        r = 8'h00;
        if (a == KP || a == DP) begin
            if (!m_cfg) r = 8'hFF;
            else if (a == KP) r = m_idx;
            else if (m_idx == 8'h07) r = m_ldn;
            else if (m_idx == 8'h20) r = 8'h30;
            else if (m_idx == 8'h21) r = 8'h01;
            else if (m_ldn < NDEV) begin
                case (m_idx)
                    8'h30: r = {7'b0, m_en[m_ldn]};
                    8'h60: r = m_pri[m_ldn][15:8];
                    8'h61: r = m_pri[m_ldn][7:0];
                    8'h62: r = m_sec[m_ldn][15:8];
                    8'h63: r = m_sec[m_ldn][7:0];
                    8'h70: r = m_ip[m_ldn];
                    8'h72: r = m_is[m_ldn];
                    8'hF0: r = m_d0[m_ldn];
                    8'hF1: r = m_d1[m_ldn];
                    default: if (m_ldn == 8 && m_idx >= 8'hC0 && m_idx <= 8'hEF)
                                 r = {3'b000, m_g[m_idx - 8'hC0]};
                endcase
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, v);
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [15:0] a);
        logic [7:0] v;
        bus_read(a, v);
        check(req, {24'h0, v}, {24'h0, model_read(a)});
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] v);
        bus_write(KP, idx);
        bus_write(DP, v);
    endtask

    task automatic reg_check(input string req, input logic [7:0] idx);
        bus_write(KP, idx);
        read_check(req, DP);
    endtask

    task automatic check_outputs();
        #1;
        check("R3 cfg_active", {31'h0, cfg_active}, {31'h0, m_cfg});
        for (int d = 0; d < NDEV; d++) begin
            check("R7 dev_enable", {31'h0, dev_enable[d]}, {31'h0, m_en[d]});
            check("R8 dev_base_pri", {16'h0, dev_base_pri[d*16 +: 16]}, {16'h0, m_pri[d]});
            check("R8 dev_base_sec", {16'h0, dev_base_sec[d*16 +: 16]}, {16'h0, m_sec[d]});
            check("R9 dev_irq_pri", {24'h0, dev_irq_pri[d*8 +: 8]}, {24'h0, m_ip[d]});
            check("R9 dev_irq_sec", {24'h0, dev_irq_sec[d*8 +: 8]}, {24'h0, m_is[d]});
        end
    endtask

    task automatic both_strobes(input string req, input logic [7:0] v);
        logic [7:0] got;
        @(negedge clk);
        bus_addr = DP; bus_wdata = v; bus_wr = 1'b1; bus_rd = 1'b1;
        #1 got = bus_rdata;
        check(req, {24'h0, got}, {24'h0, model_read(DP)});
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        model_write(DP, v);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] pick [16];
        void'($urandom(32'd2718));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_outputs();
        check("R1 cfg_active after reset", {31'h0, cfg_active}, 32'h0);

        // R2 locked behaviour
        read_check("R2 data read locked", DP);
        read_check("R2 key read locked", KP);
        bus_write(DP, 8'h5A);
        bus_write(KP, 8'h12);
        bus_write(KP, 8'hAA);
        check_outputs();
        check("R2 stray key stays locked", {31'h0, cfg_active}, 32'h0);

        // R3 enter
        bus_write(KP, 8'h55);
        check("R3 enter", {31'h0, cfg_active}, 32'h1);
        reg_check("R1 ldn zero after reset", 8'h07);

        // R6 identity, read-only
        reg_check("R6 id", 8'h20);
        bus_write(DP, 8'hEE);
        read_check("R6 id write ignored", DP);
        reg_check("R6 rev", 8'h21);
        bus_write(DP, 8'h77);
        read_check("R6 rev write ignored", DP);

        // R5 ldn and R7/R8/R9 per-device
        reg_write(8'h07, 8'h04);
        reg_check("R5 ldn readback", 8'h07);
        reg_write(8'h30, 8'hFF);
        reg_check("R7 enable reads 01", 8'h30);
        reg_write(8'h60, 8'h03);
        reg_write(8'h61, 8'hF8);
        reg_write(8'h62, 8'h02);
        reg_write(8'h63, 8'hF8);
        reg_write(8'h70, 8'h04);
        reg_write(8'h72, 8'h0B);
        reg_write(8'hF0, 8'h0C);
        reg_write(8'hF1, 8'h5D);
        reg_check("R9 decoder byte 0", 8'hF0);
        reg_check("R9 decoder byte 1", 8'hF1);
        reg_check("R8 primary high", 8'h60);
        check_outputs();
        reg_write(8'h07, 8'h01);
        reg_check("R5 other bank untouched", 8'h61);

        // R10 aux GPIO
        reg_write(8'h07, 8'h08);
        reg_write(8'hC2, 8'hFF);
        reg_check("R10 gpio keeps low 5 bits", 8'hC2);
        reg_write(8'hEF, 8'h09);
        reg_check("R10 gpio last", 8'hEF);
        reg_write(8'h07, 8'h02);
        reg_check("R10 gpio hidden outside aux bank", 8'hC2);

        // R11 unimplemented / bad ldn
        reg_check("R11 unimplemented index", 8'h45);
        reg_write(8'h07, 8'h0C);
        reg_write(8'h30, 8'h01);
        reg_write(8'h70, 8'h09);
        reg_check("R11 high ldn read", 8'h30);
        check_outputs();

        // R4 other addresses
        bus_write(16'h03F2, 8'hAA);
        check("R4 other address no exit", {31'h0, cfg_active}, 32'h1);
        read_check("R4 other address reads zero", 16'h02F0);
        read_check("R4 key port reads index", KP);

        // R12 simultaneous strobes
        bus_write(KP, 8'h07);
        both_strobes("R12 ldn read before write", 8'h05);
        read_check("R12 ldn write landed", DP);
        bus_write(KP, 8'h30);
        both_strobes("R12 enable read before write", 8'h01);
        read_check("R12 enable write landed", DP);
        check_outputs();

        // R3 exit keeps index
        bus_write(KP, 8'h61);
        bus_write(KP, 8'hAA);
        check("R3 exit", {31'h0, cfg_active}, 32'h0);
        read_check("R2 locked after exit", DP);
        bus_write(KP, 8'h55);
        read_check("R3 index kept over exit", KP);

        // random traffic
        pick = '{8'h07, 8'h20, 8'h21, 8'h30, 8'h60, 8'h61, 8'h62, 8'h63,
                 8'h70, 8'h72, 8'hF0, 8'hF1, 8'h44, 8'hC0, 8'hD5, 8'hEF};
        for (int n = 0; n < 1500; n++) begin
            int unsigned r;
            r = $urandom % 12;
            case (r)
                0: bus_write(KP, 8'h55);
                1: if ($urandom % 4 == 0) bus_write(KP, 8'hAA);
                2: bus_write(KP, 8'($urandom));
                3, 4: bus_write(KP, pick[$urandom % 16]);
                5, 6: begin
                    if (m_idx == 8'h07) bus_write(DP, 8'($urandom % 11));
                    else bus_write(DP, 8'($urandom));
                end
                7, 8: read_check("R4 random data read", DP);
                9: read_check("R4 random key read", KP);
                10: both_strobes("R12 random dual strobe", 8'($urandom));
                default: check_outputs();
            endcase
        end
        check_outputs();

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule